// File: doc/BRIEF.md
# Move-Instruction Decoder with Destination Prefix

This block decodes the fixed 16-bit instruction words of a transport-triggered, accumulator-based core. In this core every operation is a move from a source to a destination register. Each accepted word is split into two descriptors:

- **Source descriptor.** This is either an 8-bit immediate or a module/register pair.
- **Destination descriptor.** This is a module number and a register index.

The descriptors are presented on registered outputs one cycle after the word is accepted. A single-cycle strobe marks each decoded move for the register file.

A destination field carries only three index bits, so it can name just the low eight registers of a module. To reach the upper registers of a module, software first writes a dedicated prefix register. The two low bits of that write's source field are held. They are then placed above the 3-bit subindex of the very next accepted instruction, which forms a 5-bit destination index (0 to 31). The prefix write produces no move of its own, so a prefixed move costs exactly one more instruction cycle than a plain one. The held bits are cleared once they have been used, and on reset.

Top module: `mvdec_top`

## Requirements
- R1: While and after synchronous reset, `mv_valid`, `mv_imm`, `dst_mod`, `dst_idx`, `src_mod`, `src_idx` and `src_imm` are all zero, and the held prefix is zero.
- R2: An accepted word (`instr_valid` high at a rising edge) that is not a prefix write drives `mv_valid` high for exactly the next cycle. Words accepted on consecutive edges give one strobe per cycle.
- R3: When word bit 15 is 0 (register source), `mv_imm` is 0, `src_mod` equals word bits 3:0 and `src_idx` equals word bits 7:4.
- R4: When word bit 15 is 1 (immediate source), `mv_imm` is 1 and `src_imm` equals word bits 7:0 zero-extended to 16 bits.
- R5: `dst_mod` equals word bits 11:8, and `dst_idx[2:0]` equals word bits 14:12.
- R6: A word whose destination module is 11 and whose 3-bit subindex is 0 is a prefix write. It raises no `mv_valid` and loads bits 1:0 of its source field, in either source format, into the held prefix. A word to module 11 with a nonzero subindex is an ordinary move.
- R7: The first accepted non-prefix word after a prefix write gets the held prefix as `dst_idx[4:3]`.
- R8: The held prefix clears to zero once that word is accepted, so the following move has `dst_idx[4:3]` = 0.
- R9: Cycles with `instr_valid` low neither raise `mv_valid` nor change or consume the held prefix.
- R10: A second prefix write before any move replaces the held value.
- R11: While `mv_valid` is low, all descriptor outputs keep their last decoded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | The instruction word is accepted at this edge |
| instr_word | input | 16 | Instruction word |
| mv_valid | output | 1 | A decoded move is present (one cycle per move) |
| mv_imm | output | 1 | The source is an immediate |
| src_mod | output | 4 | Source module (register format) |
| src_idx | output | 4 | Source register index within the module |
| src_imm | output | 16 | Zero-extended immediate source |
| dst_mod | output | 4 | Destination module |
| dst_idx | output | 5 | Destination index, with the prefix above the subindex |

## Verification
The bench aims at the prefix lifetime.

- **Prefix must not outlive one move.** A design that never clears the prefix would show a widened index on the second move as well.
- **Idle cycles must not consume the prefix.** A design that clears on idle cycles would lose the prefix across gaps in `instr_valid`.
- **A repeated prefix write must replace the held value.** A design that ORs successive prefix writes would give a wrong index after two prefix writes.
- **The prefix write itself must stay silent.** A design that strobes on it would issue a spurious move.

Back-to-back words test that the strobe neither drops nor stretches. Module 11 with a nonzero subindex and the 0xFF immediate test the edges of prefix detection and of zero-extension.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;
  localparam int INSTR_W = 16;
  localparam int SRC_W   = 8;
  localparam int MOD_W   = 4;
  localparam int RIDX_W  = 4;
  localparam int SUB_W   = 3;

  typedef struct packed {
    logic               imm;
    logic [SUB_W-1:0]   dsub;
    logic [MOD_W-1:0]   dmod;
    logic [SRC_W-1:0]   src;
  } fields_t;
endpackage

// File: rtl/mvdec_field_split.sv
module mvdec_field_split
  import mvdec_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output fields_t            fields_o
);
  // bit 15 = format, 14:12 = dst subindex, 11:8 = dst module, 7:0 = source
  always_comb begin
    fields_o.imm  = word_i[15];
    fields_o.dsub = word_i[14:12];
    fields_o.dmod = word_i[11:8];
    fields_o.src  = word_i[7:0];
  end
endmodule

// File: rtl/mvdec_prefix_reg.sv
module mvdec_prefix_reg
  import mvdec_pkg::*;
#(
  parameter int PFX_W   = 2,
  parameter int PFX_MOD = 11,
  parameter int PFX_SUB = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic [MOD_W-1:0]   dmod_i,
  input  logic [SUB_W-1:0]   dsub_i,
  input  logic [PFX_W-1:0]   load_val_i,
  output logic               is_pfx_o,
  output logic [PFX_W-1:0]   pfx_q_o
);
  localparam logic [MOD_W-1:0] PMOD = MOD_W'(PFX_MOD);
  localparam logic [SUB_W-1:0] PSUB = SUB_W'(PFX_SUB);

  assign is_pfx_o = (dmod_i == PMOD) && (dsub_i == PSUB);

  always_ff @(posedge clk) begin
    if (rst)
      pfx_q_o <= '0;
    else if (valid_i && is_pfx_o)
      pfx_q_o <= load_val_i;
    else if (valid_i)
      pfx_q_o <= '0;
  end

  // R6: a prefix write loads the source bits
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_pfx_o |=> pfx_q_o == $past(load_val_i));
  // R8: a consumed prefix is cleared
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    valid_i && !is_pfx_o |=> pfx_q_o == '0);
  // R9: idle cycles keep the prefix
  p_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(pfx_q_o));
endmodule

// File: rtl/mvdec_out_reg.sv
module mvdec_out_reg
  import mvdec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PFX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire_i,
  input  fields_t                 fields_i,
  input  logic [PFX_W-1:0]        pfx_i,
  output logic                    mv_valid_o,
  output logic                    mv_imm_o,
  output logic [MOD_W-1:0]        src_mod_o,
  output logic [RIDX_W-1:0]       src_idx_o,
  output logic [DATA_W-1:0]       src_imm_o,
  output logic [MOD_W-1:0]        dst_mod_o,
  output logic [SUB_W+PFX_W-1:0]  dst_idx_o
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (DATA_W > SRC_W) begin : g_zext
      assign imm_ext = {{(DATA_W-SRC_W){1'b0}}, fields_i.src};
    end else begin : g_trunc
      assign imm_ext = fields_i.src[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mv_valid_o <= 1'b0;
      mv_imm_o   <= 1'b0;
      src_mod_o  <= '0;
      src_idx_o  <= '0;
      src_imm_o  <= '0;
      dst_mod_o  <= '0;
      dst_idx_o  <= '0;
    end else begin
      mv_valid_o <= fire_i;
      if (fire_i) begin
        mv_imm_o  <= fields_i.imm;
        src_mod_o <= fields_i.src[MOD_W-1:0];
        src_idx_o <= fields_i.src[MOD_W+RIDX_W-1:MOD_W];
        src_imm_o <= imm_ext;
        dst_mod_o <= fields_i.dmod;
        dst_idx_o <= {pfx_i, fields_i.dsub};
      end
    end
  end

  // R2: each fire gives one strobe cycle
  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> mv_valid_o);
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> !mv_valid_o);
  // R11: descriptors hold without a move
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !fire_i |=> $stable(dst_mod_o) && $stable(dst_idx_o) && $stable(src_imm_o));
endmodule

// File: rtl/mvdec_top.sv
module mvdec_top
  import mvdec_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PFX_W   = 2,
  parameter int PFX_MOD = 11,
  parameter int PFX_SUB = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instr_valid,
  input  logic [15:0]             instr_word,
  output logic                    mv_valid,
  output logic                    mv_imm,
  output logic [3:0]              src_mod,
  output logic [3:0]              src_idx,
  output logic [DATA_W-1:0]       src_imm,
  output logic [3:0]              dst_mod,
  output logic [SUB_W+PFX_W-1:0]  dst_idx
);
  fields_t            fields;
  logic               is_pfx;
  logic [PFX_W-1:0]   pfx_q;
  logic               fire;

  mvdec_field_split u_split (
    .word_i   (instr_word),
    .fields_o (fields)
  );

  mvdec_prefix_reg #(
    .PFX_W   (PFX_W),
    .PFX_MOD (PFX_MOD),
    .PFX_SUB (PFX_SUB)
  ) u_pfx (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (instr_valid),
    .dmod_i     (fields.dmod),
    .dsub_i     (fields.dsub),
    .load_val_i (fields.src[PFX_W-1:0]),
    .is_pfx_o   (is_pfx),
    .pfx_q_o    (pfx_q)
  );

  assign fire = instr_valid && !is_pfx;

  mvdec_out_reg #(
    .DATA_W (DATA_W),
    .PFX_W  (PFX_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .fire_i     (fire),
    .fields_i   (fields),
    .pfx_i      (pfx_q),
    .mv_valid_o (mv_valid),
    .mv_imm_o   (mv_imm),
    .src_mod_o  (src_mod),
    .src_idx_o  (src_idx),
    .src_imm_o  (src_imm),
    .dst_mod_o  (dst_mod),
    .dst_idx_o  (dst_idx)
  );

  // R6: a prefix write never strobes a move
  p_no_move_on_pfx_r6: assert property (@(posedge clk) disable iff (rst)
    instr_valid && is_pfx |=> !mv_valid);
  // R4: immediates carry no bits above the source field
  p_imm_ext_r4: assert property (@(posedge clk) disable iff (rst)
    mv_valid && mv_imm |-> (src_imm >> SRC_W) == '0);
endmodule

// File: tb/mvdec_top_tb.sv
module mvdec_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic        mv_valid, mv_imm;
  logic [3:0]  src_mod, src_idx, dst_mod;
  logic [15:0] src_imm;
  logic [4:0]  dst_idx;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  mvdec_top u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .mv_valid(mv_valid), .mv_imm(mv_imm), .src_mod(src_mod), .src_idx(src_idx),
    .src_imm(src_imm), .dst_mod(dst_mod), .dst_idx(dst_idx)
  );

  function automatic logic [15:0] mk_reg(input logic [2:0] dsub, input logic [3:0] dmod,
                                         input logic [3:0] sidx, input logic [3:0] smod);
    return {1'b0, dsub, dmod, sidx, smod};
  endfunction
  function automatic logic [15:0] mk_imm(input logic [2:0] dsub, input logic [3:0] dmod,
                                         input logic [7:0] imm);
    return {1'b1, dsub, dmod, imm};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one word for a single edge, return at the negedge after it
  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    instr_word  = w;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "mv_valid", mv_valid, 0);
    chk("R1", "mv_imm", mv_imm, 0);
    chk("R1", "dst_idx", dst_idx, 0);
    chk("R1", "dst_mod", dst_mod, 0);
    chk("R1", "src_imm", src_imm, 0);
    // R1: no stale prefix after reset
    issue(mk_reg(3'd4, 4'd2, 4'd1, 4'd1));
    chk("R1", "dst_idx after reset", dst_idx, 4);
  endtask

  task automatic t_reg_move;
    issue(mk_reg(3'd5, 4'd7, 4'hA, 4'h3));
    chk("R2", "mv_valid", mv_valid, 1);
    chk("R3", "mv_imm", mv_imm, 0);
    chk("R3", "src_mod", src_mod, 3);
    chk("R3", "src_idx", src_idx, 10);
    chk("R5", "dst_mod", dst_mod, 7);
    chk("R5", "dst_idx", dst_idx, 5);
    idle(1);
    chk("R2", "single pulse", mv_valid, 0);
    chk("R11", "dst_mod hold", dst_mod, 7);
    chk("R11", "src_idx hold", src_idx, 10);
  endtask

  task automatic t_imm_move;
    issue(mk_imm(3'd2, 4'd4, 8'hC5));
    chk("R4", "mv_imm", mv_imm, 1);
    chk("R4", "src_imm", src_imm, 16'h00C5);
    chk("R5", "dst_mod", dst_mod, 4);
    chk("R5", "dst_idx", dst_idx, 2);
    issue(mk_imm(3'd7, 4'd15, 8'hFF));
    chk("R4", "src_imm max", src_imm, 16'h00FF);
    chk("R5", "dst_idx max", dst_idx, 7);
    chk("R5", "dst_mod max", dst_mod, 15);
  endtask

  task automatic t_prefix_basic;
    issue(mk_imm(3'd0, 4'd11, 8'h03));
    chk("R6", "no strobe on prefix", mv_valid, 0);
    chk("R11", "dst_mod held over prefix", dst_mod, 15);
    idle(3);                                   // R9 gaps keep the prefix
    chk("R9", "no strobe when idle", mv_valid, 0);
    issue(mk_reg(3'd6, 4'd9, 4'd2, 4'd5));
    chk("R7", "widened dst_idx", dst_idx, 30);
    chk("R7", "mv_valid", mv_valid, 1);
    issue(mk_reg(3'd6, 4'd9, 4'd2, 4'd5));
    chk("R8", "prefix cleared", dst_idx, 6);
  endtask

  task automatic t_prefix_replace;
    issue(mk_imm(3'd0, 4'd11, 8'h01));
    issue(mk_reg(3'd0, 4'd11, 4'd4, 4'd2));    // register format, source bits 1:0 = 2
    chk("R10", "no strobe", mv_valid, 0);
    issue(mk_reg(3'd1, 4'd2, 4'd0, 4'd0));
    chk("R10", "replaced prefix", dst_idx, 17);
    // R6: module 11 with nonzero subindex is an ordinary move
    issue(mk_reg(3'd1, 4'd11, 4'd0, 4'd3));
    chk("R6", "mod11 sub1 strobes", mv_valid, 1);
    chk("R6", "mod11 sub1 idx", dst_idx, 1);
    chk("R6", "mod11 sub1 mod", dst_mod, 11);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    instr_word = mk_imm(3'd0, 4'd11, 8'h01); instr_valid = 1'b1;
    @(negedge clk);
    chk("R6", "b2b prefix silent", mv_valid, 0);
    instr_word = mk_reg(3'd3, 4'd6, 4'd1, 4'd1);
    @(negedge clk);
    chk("R2", "b2b move1 strobe", mv_valid, 1);
    chk("R7", "b2b move1 idx", dst_idx, 11);
    instr_word = mk_imm(3'd7, 4'd5, 8'h10);
    @(negedge clk);
    chk("R2", "b2b move2 strobe", mv_valid, 1);
    chk("R8", "b2b move2 idx", dst_idx, 7);
    chk("R5", "b2b move2 mod", dst_mod, 5);
    instr_valid = 1'b0;
    @(negedge clk);
    chk("R2", "b2b end", mv_valid, 0);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    instr_valid = 1'b0;
    instr_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_move();
    t_imm_move();
    t_prefix_basic();
    t_prefix_replace();
    t_back_to_back();
    finish_run();
  end
endmodule